// File: doc/BRIEF.md
# Bit-Serial Unsigned Multiplier Datapath

This block multiplies a parallel unsigned multiplicand by a multiplier that arrives one bit per clock, least significant bit first, and returns the product one bit per clock, also least significant bit first. The multiplicand is held on a WIDTH-bit bus for the whole operation. Each cycle, every stage gates one multiplicand bit with the current serial bit. It then adds that partial product to the registered sum of the stage above it and to its own registered carry. Stage 0's registered sum is the serial product output.

For a WIDTH x WIDTH multiply, the surrounding controller drives the WIDTH multiplier bits and then WIDTH zero bits, so the pending carries drain out. It marks the first bit of every operation with a start pulse. The start pulse makes the chain discard whatever the previous operation left behind, so operations can follow each other with no idle cycle. Operand loading, bit counting and assembly of the 2*WIDTH-bit result stay outside the block.

Top module: `spm_serial_mult`

## Requirements
- R1: While `rst_i` is high at a clock edge, all sum and carry registers clear, and `p_o` reads 0 in the following cycle.
- R2: Exactly one multiplier bit is taken from `y_i` at each rising edge. Product bit k appears on `p_o` in the cycle that follows the edge at which multiplier bit k was taken.
- R3: When the multiplier bits are driven at positions 0..WIDTH-1 and zeros at positions WIDTH..2*WIDTH-1, the 2*WIDTH bits on `p_o` form the full unsigned product, with no loss of bits.
- R4: A cycle with `start_i` high treats `y_i` as bit 0 of a new operation. All state left by earlier operations is ignored, so the next `p_o` equals `a_i[0] & y_i`, even after an operation that was abandoned midway.
- R5: A new operation may start in the cycle right after the last flush bit of the previous one, and both products come out correct.
- R6: With both operands at their all-ones maximum, the product is exact, including the top bit.
- R7: From a start, as long as `y_i` stays 0, `p_o` stays 0 in each following cycle, whatever the multiplicand.
- R8: From a start, as long as `a_i` equals 1, `p_o` repeats `y_i` one cycle later.
- R9: After reset, `p_o` is never unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Marks the first serial bit of a new operation |
| a_i | input | WIDTH | Parallel multiplicand, held for the whole operation |
| y_i | input | 1 | Serial multiplier bit, LSB first |
| p_o | output | 1 | Serial product bit, LSB first |

## Verification
Each product bit is due exactly one cycle after the edge that takes its multiplier bit, and the reset result is due one cycle after the reset edge. The bench drives inputs on the falling edge. For every driven bit it queues the expected product bit, and that entry is released to the monitor only at the next rising edge. The monitor compares each entry at the following falling edge, so every result is checked in the single cycle in which it is due. Abandoned operations, back-to-back starts and a reset in the middle of an operation are placed so that each one's due cycle falls directly after a previous result.

// File: rtl/spm_pkg.sv
package spm_pkg;
    // result of one carry-save cell
    typedef struct packed {
        logic sum;
        logic cry;
    } fa_t;
endpackage

// File: rtl/spm_androw.sv
module spm_androw #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] mcand_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] pp_o
);
    always_comb begin
        pp_o = mcand_i & {WIDTH{bit_i}};
    end
endmodule

// File: rtl/spm_fa.sv
module spm_fa
    import spm_pkg::*;
(
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output fa_t  r_o
);
    always_comb begin
        r_o.sum = x_i ^ y_i ^ z_i;
        r_o.cry = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
    end
endmodule

// File: rtl/spm_chain.sv
module spm_chain
    import spm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] pp_i,
    input  logic [WIDTH-1:0] sum_i,
    input  logic [WIDTH-1:0] cry_i,
    output logic [WIDTH-1:0] sum_o,
    output logic [WIDTH-1:0] cry_o
);
    localparam int TOP = WIDTH - 1;

    // stage i adds the sum of stage i+1 (shift right by one weight)
    logic [WIDTH-1:0] shifted;
    always_comb begin
        shifted = {1'b0, sum_i[TOP:1]};
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        fa_t res;
        spm_fa u_fa (
            .x_i (pp_i[i]),
            .y_i (shifted[i]),
            .z_i (cry_i[i]),
            .r_o (res)
        );
        assign sum_o[i] = res.sum;
        assign cry_o[i] = res.cry;
    end
endmodule

// File: rtl/spm_serial_mult.sv
module spm_serial_mult #(
    parameter int WIDTH = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic             y_i,
    output logic             p_o
);
    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic [WIDTH-1:0] cry;
    } state_t;

    state_t           st_d, st_q;
    logic [WIDTH-1:0] pp;
    logic [WIDTH-1:0] sum_src, cry_src;
    logic [WIDTH-1:0] sum_nx, cry_nx;

    spm_androw #(.WIDTH(WIDTH)) u_and (
        .mcand_i (a_i),
        .bit_i   (y_i),
        .pp_o    (pp)
    );

    spm_chain #(.WIDTH(WIDTH)) u_chain (
        .pp_i  (pp),
        .sum_i (sum_src),
        .cry_i (cry_src),
        .sum_o (sum_nx),
        .cry_o (cry_nx)
    );

    always_comb begin
        // a start drops the previous operation's residue
        sum_src  = start_i ? '0 : st_q.sum;
        cry_src  = start_i ? '0 : st_q.cry;
        st_d.sum = sum_nx;
        st_d.cry = cry_nx;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign p_o = st_q.sum[0];
endmodule

// File: rtl/spm_serial_mult_chk.sv
module spm_serial_mult_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic [WIDTH-1:0] a_i,
    input logic             y_i,
    input logic             p_o
);
    logic unit_trk, unit_run_q;
    logic zero_trk, zero_run_q;

    assign unit_trk = (start_i || unit_run_q) && (a_i == WIDTH'(1));
    assign zero_trk = (start_i || zero_run_q) && !y_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            unit_run_q <= 1'b0;
            zero_run_q <= 1'b0;
        end else begin
            unit_run_q <= unit_trk;
            zero_run_q <= zero_trk;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> !p_o);

    // R4
    start_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (p_o == $past(a_i[0] & y_i)));

    // R7
    zero_mult_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        zero_trk |=> !p_o);

    // R8
    unit_mcand_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        unit_trk |=> (p_o == $past(y_i)));

    // R9
    known_out_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$isunknown(p_o));
endmodule

bind spm_serial_mult spm_serial_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (start_i),
    .a_i     (a_i),
    .y_i     (y_i),
    .p_o     (p_o)
);

// File: tb/sim_spm_serial_mult.sv
module sim_spm_serial_mult;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_i = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic         y_i = 1'b0;
    logic         p_o;

    int    n_run  = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    logic  vld  = 1'b0;
    logic  pend = 1'b0;
    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    spm_serial_mult #(.WIDTH(W)) u0 (
        .clk_i   (clk),
        .rst_i   (rst_i),
        .start_i (start_i),
        .a_i     (a_i),
        .y_i     (y_i),
        .p_o     (p_o)
    );

    // an entry queued at a falling edge is due after the next rising edge
    always @(posedge clk) pend <= vld;

    // monitor: compare one queued bit per cycle
    always @(negedge clk) begin
        if (pend && exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (p_o !== e) begin
                n_fail++;
                $display("FAIL %s: p_o=%b expected %b at %0t", t, p_o, e, $time);
            end
        end
    end

    task automatic check_now(input logic exp, input string tag);
        n_run++;
        if (p_o !== exp) begin
            n_fail++;
            $display("FAIL %s: p_o=%b expected %b", tag, p_o, exp);
        end
    endtask

    // driver: nbits serial bits of one operation, LSB first, zero fill above W
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int nbits, input string tag);
        logic [2*W-1:0] prod;
        prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        for (int k = 0; k < nbits; k++) begin
            @(negedge clk);
            a_i     = a;
            start_i = (k == 0);
            y_i     = (k < W) ? b[k] : 1'b0;
            vld     = 1'b1;
            exp_q.push_back(prod[k]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            start_i = 1'b0;
            y_i     = 1'b0;
            vld     = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_i = 1'b0;
        @(negedge clk);
        check_now(1'b0, "R1 reset state");

        // R2 R3 small and mixed operands
        run_op(32'd3, 32'd10, 2*W, "R2 3x10");
        idle(2);
        run_op(32'hDEADBEEF, 32'h12345678, 2*W, "R3 mixed");
        // R5 back-to-back, no gap
        run_op(32'h8000_0001, 32'hF0F0_0F0F, 2*W, "R5 back-to-back A");
        run_op(32'h0000_FFFF, 32'hFFFF_0000, 2*W, "R5 back-to-back B");
        // R6 maximum operands
        run_op('1, '1, 2*W, "R6 max x max");
        // R7 zero multiplier
        run_op(32'hA5A5_5A5A, 32'd0, 2*W, "R7 zero multiplier");
        // R8 unit multiplicand
        run_op(32'd1, 32'hC3A5_9617, 2*W, "R8 unit multiplicand");
        // R4 abandon an operation with heavy residue, restart at once
        run_op('1, '1, 40, "R4 abandoned");
        run_op(32'd7, 32'd9, 2*W, "R4 restart after abandon");
        run_op('1, 32'h7FFF_FFFF, 20, "R4 abandoned again");
        run_op(32'h0001_0000, 32'h0001_0000, 2*W, "R4 restart high bits");

        // R1 reset in the middle of an operation
        run_op('1, '1, 10, "R1 before reset");
        @(negedge clk);
        start_i = 1'b0;
        y_i     = 1'b1;
        vld     = 1'b0;
        rst_i   = 1'b1;
        @(negedge clk);
        rst_i = 1'b0;
        y_i   = 1'b0;
        check_now(1'b0, "R1 mid-op reset");
        run_op(32'd12345, 32'd6789, 2*W, "R9 after reset");
        idle(3);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule